// File: doc/BRIEF.md
# Low-Power Stop Entry Handshake

This block watches a processor-side bus for the write that announces entry into low-power stop mode. The announcement is a write in the CPU address space, identified by function code 7, whose cycle-type field in the address equals 3. The low data bits of that write carry a 3-bit interrupt mask level, which the block captures. The block answers the cycle with its own data-size acknowledge, so no external device has to respond.

The broadcast is accepted only when the bus is free, so a pending broadcast simply waits while another master holds the bus. After the acknowledge, the block arms itself and raises the stop request toward a clock controller. It does this only once an external hold line is released. The hold line passes through a small synchronizer first. The captured mask level stays on its output for the whole stop period, so a clock controller can decide which interrupt levels may wake the system. A wake-up pulse or a reset ends the stop period and clears the request and the mask.

Top module: `lps_stop_entry`

## Requirements
- R1: After reset, `cyc_ack` and `stop_req` are 0 and `wake_mask` is 0.
- R2: A cycle is a stop broadcast only when all of the following hold at a rising edge in the idle state: `cyc_valid`=1, `cyc_write`=1, `cyc_fc`=7, `cyc_type`=3 and `bus_idle`=1. In that case `cyc_ack` is 1 for the cycle that follows that edge.
- R3: At the edge that accepts a broadcast, `wake_mask` takes the value of `cyc_mask_data[2:0]`. It shows that value in the same cycle as the acknowledge.
- R4: A read, a write with a function code other than 7, or a CPU-space write whose type field is not 3 produces no acknowledge and no stop request, and leaves `wake_mask` unchanged.
- R5: While `bus_idle`=0, a broadcast cycle is not acknowledged. It is acknowledged at the first edge at which `bus_idle`=1.
- R6: When the hold line has been low and settled, `stop_req` rises two edges after the edge at which `cyc_ack` rose. It is 0 in the cycle directly after the acknowledge.
- R7: `hold_req` reaches the control logic through HOLD_SYNC flops, which reset to the held value. While the synchronized hold is 1, `stop_req` stays 0. After `hold_req` falls, `stop_req` rises on the (HOLD_SYNC+1)-th edge.
- R8: `stop_req` and `wake_mask` hold their values until `wake_pulse`=1 is seen at an edge. That edge returns both to 0. A wake pulse while waiting for the hold release cancels stop entry.
- R9: While a broadcast is being acknowledged, waiting for the hold release, or in stop, further broadcasts are neither acknowledged nor captured.
- R10: `cyc_ack` is a single-cycle pulse, even if `cyc_valid` stays asserted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | A bus cycle is presented |
| cyc_write | input | 1 | 1 = write cycle |
| cyc_fc | input | 3 | Function code (address space) of the cycle |
| cyc_type | input | 4 | Cycle-type field taken from the address |
| cyc_mask_data | input | 3 | Low data bits carrying the mask level |
| bus_idle | input | 1 | No other master owns the bus |
| hold_req | input | 1 | External request to delay stop entry (asynchronous) |
| wake_pulse | input | 1 | Ends stop mode |
| cyc_ack | output | 1 | Internally generated cycle acknowledge |
| stop_req | output | 1 | Request to enter low-power stop |
| wake_mask | output | 3 | Captured interrupt mask level |

## Verification
The hardest situation to reach is the waiting window between the acknowledge and stop entry. There the outcome depends on the synchronized hold value, and a wake pulse or a second broadcast can arrive. The stimulus raises `hold_req` several cycles before a broadcast, so that the synchronizer is already saturated. It then holds the block in that window for a known number of cycles. While the block waits, the bench fires a second broadcast and, separately, a wake pulse. It then drops the hold line and counts edges against HOLD_SYNC. A full sweep over all function codes, type values and directions separately covers the decode.

// File: rtl/lps_pkg.sv
package lps_pkg;

  // Control states of the stop entry handshake
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_ARM  = 2'd2,
    ST_STOP = 2'd3
  } lps_state_e;

endpackage

// File: rtl/lps_decode.sv
module lps_decode #(
  parameter int FC_W      = 3,
  parameter int TYPE_W    = 4,
  parameter int CPU_FC    = 7,
  parameter int STOP_TYPE = 3
) (
  input  logic              cyc_valid,
  input  logic              cyc_write,
  input  logic [FC_W-1:0]   cyc_fc,
  input  logic [TYPE_W-1:0] cyc_type,
  input  logic              bus_idle,
  output logic              bcast_hit
);

  localparam logic [FC_W-1:0]   CPU_CODE  = FC_W'(CPU_FC);
  localparam logic [TYPE_W-1:0] STOP_CODE = TYPE_W'(STOP_TYPE);

  // Address-space test: CPU space only
  function automatic logic in_cpu_space(input logic [FC_W-1:0] fc);
    return fc == CPU_CODE;
  endfunction

  // The stop broadcast is a write of one particular cycle type
  function automatic logic is_stop_write(input logic wr, input logic [TYPE_W-1:0] ty);
    return wr && (ty == STOP_CODE);
  endfunction

  logic space_ok;
  logic kind_ok;

  assign space_ok  = in_cpu_space(cyc_fc);
  assign kind_ok   = is_stop_write(cyc_write, cyc_type);
  assign bcast_hit = cyc_valid && bus_idle && space_ok && kind_ok;

endmodule

// File: rtl/lps_hold_sync.sv
module lps_hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_in,
  output logic hold_s
);

  generate
    if (STAGES == 0) begin : g_direct
      assign hold_s = hold_in;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sr <= '1;   // treat hold as present until it is seen low
        end else begin
          sr[0] <= hold_in;
          for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
        end
      end
      assign hold_s = sr[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
  import lps_pkg::*;
#(
  parameter int MASK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bcast_hit,
  input  logic              hold_s,
  input  logic              wake,
  input  logic [MASK_W-1:0] mask_in,
  output logic              ack,
  output logic              stop_req,
  output logic [MASK_W-1:0] mask_q
);

  lps_state_e state, state_nx;
  logic       accept;
  logic       leave;

  assign accept = (state == ST_IDLE) && bcast_hit;
  assign leave  = (state != ST_IDLE) && wake;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (bcast_hit) state_nx = ST_ACK;
      ST_ACK:  state_nx = wake ? ST_IDLE : ST_ARM;
      ST_ARM:  if (wake) state_nx = ST_IDLE;
               else if (!hold_s) state_nx = ST_STOP;
      ST_STOP: if (wake) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mask_q <= '0;
    end else begin
      state <= state_nx;
      if (accept)     mask_q <= mask_in;
      else if (leave) mask_q <= '0;
    end
  end

  assign ack      = (state == ST_ACK);
  assign stop_req = (state == ST_STOP);

  // R10: acknowledge never lasts two cycles
  p_ack_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R6: no stop request in the cycle right after the acknowledge
  p_gap_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !stop_req);

  // R7: stop entry only when the synchronized hold was low
  p_hold_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req) |-> !$past(hold_s));

  // R8: stop persists without a wake pulse
  p_stop_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !wake) |=> stop_req);

  // R8: wake clears request and mask
  p_wake_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && wake) |=> (!stop_req && mask_q == '0));

  // R9: captured mask stays fixed while busy
  p_mask_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !wake) |=> $stable(mask_q));

endmodule

// File: rtl/lps_stop_entry.sv
module lps_stop_entry #(
  parameter int FC_W      = 3,
  parameter int TYPE_W    = 4,
  parameter int MASK_W    = 3,
  parameter int CPU_FC    = 7,
  parameter int STOP_TYPE = 3,
  parameter int HOLD_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic              cyc_write,
  input  logic [FC_W-1:0]   cyc_fc,
  input  logic [TYPE_W-1:0] cyc_type,
  input  logic [MASK_W-1:0] cyc_mask_data,
  input  logic              bus_idle,
  input  logic              hold_req,
  input  logic              wake_pulse,
  output logic              cyc_ack,
  output logic              stop_req,
  output logic [MASK_W-1:0] wake_mask
);

  localparam logic [FC_W-1:0]   CPU_CODE  = FC_W'(CPU_FC);
  localparam logic [TYPE_W-1:0] STOP_CODE = TYPE_W'(STOP_TYPE);

  logic bcast_hit;
  logic hold_s;

  lps_decode #(
    .FC_W(FC_W), .TYPE_W(TYPE_W), .CPU_FC(CPU_FC), .STOP_TYPE(STOP_TYPE)
  ) u_decode (
    .cyc_valid(cyc_valid),
    .cyc_write(cyc_write),
    .cyc_fc   (cyc_fc),
    .cyc_type (cyc_type),
    .bus_idle (bus_idle),
    .bcast_hit(bcast_hit)
  );

  lps_hold_sync #(.STAGES(HOLD_SYNC)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_in(hold_req),
    .hold_s (hold_s)
  );

  lps_fsm #(.MASK_W(MASK_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .bcast_hit(bcast_hit),
    .hold_s   (hold_s),
    .wake     (wake_pulse),
    .mask_in  (cyc_mask_data),
    .ack      (cyc_ack),
    .stop_req (stop_req),
    .mask_q   (wake_mask)
  );

  // R2/R5: an acknowledge follows a complete broadcast on a free bus
  p_ack_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_ack |-> $past(cyc_valid && cyc_write && cyc_fc == CPU_CODE &&
                      cyc_type == STOP_CODE && bus_idle));

  // R3: the mask seen with the acknowledge is the data of the accepted write
  p_mask_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cyc_ack) |-> (wake_mask == $past(cyc_mask_data)));

  // R4: cycles outside CPU space never get acknowledged
  p_other_space_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_fc != CPU_CODE) |=> !cyc_ack);

  // R5: a busy bus delays the acknowledge
  p_wait_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_idle |=> !cyc_ack);

endmodule

// File: tb/lps_stop_entry_tb.sv
`timescale 1ns/1ps
module lps_stop_entry_tb;

  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_valid = 1'b0, cyc_write = 1'b0, bus_idle = 1'b1;
  logic       hold_req = 1'b0, wake_pulse = 1'b0;
  logic [2:0] cyc_fc = '0;
  logic [3:0] cyc_type = '0;
  logic [2:0] cyc_mask_data = '0;
  logic       cyc_ack, stop_req;
  logic [2:0] wake_mask;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lps_stop_entry #(.HOLD_SYNC(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
    .cyc_fc(cyc_fc), .cyc_type(cyc_type), .cyc_mask_data(cyc_mask_data),
    .bus_idle(bus_idle), .hold_req(hold_req), .wake_pulse(wake_pulse),
    .cyc_ack(cyc_ack), .stop_req(stop_req), .wake_mask(wake_mask)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic present(input logic [2:0] fc, input logic [3:0] ty,
                         input logic wr, input logic [2:0] m);
    cyc_valid = 1'b1; cyc_fc = fc; cyc_type = ty; cyc_write = wr; cyc_mask_data = m;
  endtask

  task automatic drop();
    cyc_valid = 1'b0; cyc_write = 1'b0; cyc_fc = '0; cyc_type = '0; cyc_mask_data = '0;
  endtask

  task automatic wake();
    wake_pulse = 1'b1;
    step();
    wake_pulse = 1'b0;
    chk(stop_req == 1'b0, "R8 wake clears stop", int'(stop_req), 0);
    chk(wake_mask == 3'd0, "R8 wake clears mask", int'(wake_mask), 0);
  endtask

  // Expected decode, written from the requirement text
  function automatic bit expect_hit(input int fc, input int ty, input int wr);
    return (fc == 7) && (ty == 3) && (wr == 1);
  endfunction

  initial begin
    @(negedge clk);
    repeat (3) step();
    chk(cyc_ack == 1'b0, "R1 ack at reset", int'(cyc_ack), 0);
    chk(stop_req == 1'b0, "R1 stop at reset", int'(stop_req), 0);
    chk(wake_mask == 3'd0, "R1 mask at reset", int'(wake_mask), 0);
    rst_n = 1'b1;
    repeat (SYNC + 3) step();

    // R2 R3 R4 R6: sweep every function code, type value and direction
    for (int fc = 0; fc < 8; fc++) begin
      for (int ty = 0; ty < 16; ty++) begin
        for (int wr = 0; wr < 2; wr++) begin
          logic [2:0] m;
          bit hit;
          m = 3'((fc + ty + wr * 5) % 8);
          hit = expect_hit(fc, ty, wr);
          present(3'(fc), 4'(ty), wr[0], m);
          step();
          drop();
          if (hit) begin
            chk(cyc_ack == 1'b1, "R2 broadcast acknowledged", int'(cyc_ack), 1);
            chk(wake_mask == m, "R3 mask captured", int'(wake_mask), int'(m));
            step();
            chk(cyc_ack == 1'b0 && stop_req == 1'b0, "R6 gap after ack",
                int'({cyc_ack, stop_req}), 0);
            step();
            chk(stop_req == 1'b1, "R6 stop two edges after ack", int'(stop_req), 1);
            wake();
          end else begin
            chk(cyc_ack == 1'b0, "R4 no ack for other cycle", int'(cyc_ack), 0);
            step();
            chk(stop_req == 1'b0, "R4 no stop for other cycle", int'(stop_req), 0);
            chk(wake_mask == 3'd0, "R4 mask unchanged", int'(wake_mask), 0);
          end
        end
      end
    end

    // R3: every mask value
    for (int m = 0; m < 8; m++) begin
      present(3'd7, 4'd3, 1'b1, 3'(m));
      step();
      drop();
      chk(wake_mask == 3'(m), "R3 mask value", int'(wake_mask), m);
      step(); step();
      chk(wake_mask == 3'(m), "R8 mask held in stop", int'(wake_mask), m);
      wake();
    end

    // R5: busy bus delays the broadcast
    bus_idle = 1'b0;
    present(3'd7, 4'd3, 1'b1, 3'd5);
    for (int i = 0; i < 4; i++) begin
      step();
      chk(cyc_ack == 1'b0, "R5 no ack while bus busy", int'(cyc_ack), 0);
    end
    bus_idle = 1'b1;
    step();
    drop();
    chk(cyc_ack == 1'b1, "R5 ack once bus free", int'(cyc_ack), 1);
    step(); step();
    wake();

    // R10: cycle held after the acknowledge
    present(3'd7, 4'd3, 1'b1, 3'd6);
    step();
    chk(cyc_ack == 1'b1, "R10 ack rises", int'(cyc_ack), 1);
    step();
    chk(cyc_ack == 1'b0, "R10 ack is one cycle", int'(cyc_ack), 0);
    step();
    chk(cyc_ack == 1'b0, "R10 no second ack", int'(cyc_ack), 0);
    drop();
    // R9: new broadcast during stop is ignored
    chk(stop_req == 1'b1, "R9 in stop", int'(stop_req), 1);
    present(3'd7, 4'd3, 1'b1, 3'd1);
    step();
    drop();
    chk(cyc_ack == 1'b0, "R9 no ack in stop", int'(cyc_ack), 0);
    chk(wake_mask == 3'd6, "R9 mask kept in stop", int'(wake_mask), 6);
    wake();

    // R7: hold delays entry, release timing counted in edges
    hold_req = 1'b1;
    repeat (SYNC + 2) step();
    present(3'd7, 4'd3, 1'b1, 3'd4);
    step();
    drop();
    chk(cyc_ack == 1'b1, "R7 ack while hold present", int'(cyc_ack), 1);
    for (int i = 0; i < 5; i++) begin
      step();
      chk(stop_req == 1'b0, "R7 no stop while hold", int'(stop_req), 0);
    end
    // R9: broadcast while waiting for hold release
    present(3'd7, 4'd3, 1'b1, 3'd2);
    step();
    drop();
    chk(cyc_ack == 1'b0, "R9 no ack while armed", int'(cyc_ack), 0);
    chk(wake_mask == 3'd4, "R9 mask kept while armed", int'(wake_mask), 4);
    hold_req = 1'b0;
    for (int i = 0; i < SYNC; i++) begin
      step();
      chk(stop_req == 1'b0, "R7 stop not yet after release", int'(stop_req), 0);
    end
    step();
    chk(stop_req == 1'b1, "R7 stop after release latency", int'(stop_req), 1);
    wake();

    // R8: wake while armed cancels entry
    hold_req = 1'b1;
    repeat (SYNC + 2) step();
    present(3'd7, 4'd3, 1'b1, 3'd3);
    step();
    drop();
    step();
    wake();
    hold_req = 1'b0;
    for (int i = 0; i < SYNC + 4; i++) begin
      step();
      chk(stop_req == 1'b0, "R8 cancelled entry stays off", int'(stop_req), 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule